// File: doc/BRIEF.md
# Static Memory Bus Timing Controller

This block runs transfers on an external asynchronous bus shared by up to four static memories or peripheral chips, each on its own active-low chip select. An internal client sends a request (bank number, byte offset inside that bank, direction, write data). The controller then drives address, chip select, output enable or write enable and the data lines through a fixed order of phases. Every phase length comes from the target bank's own configuration. When the transfer ends it returns read data with a one-cycle done pulse.

Each bank has a 27-bit configuration word, written through a plain write port. The word holds six cycle counts, a data-width bit (8 or 16 bits) and a page-mode bit. In page mode one request moves four consecutive data beats under a single chip-select window. The first beat takes the full access time. Each following beat takes the shorter page time.

Top module: `smc_ctrl`

## Requirements
- R1: During and right after reset, every chip select, output enable and write enable is high (inactive), the data drive enable and done are low, and req_ready is high.
- R2: A configuration write stores cfg_wdata for bank cfg_bank with these fields: address setup [3:0], chip-select setup [7:4], access [12:8], chip-select hold [16:13], address hold [20:17], page time [24:21], wide (16-bit) [25], page enable [26]. After reset every field of every bank is zero, which gives 8-bit banks without page mode.
- R3: An access runs in this order. The address is driven alone for the address-setup count. Then chip select is low with the strobe high for the chip-select-setup count. Then the strobe is low for access+1 cycles. Then chip select stays low with the strobe released for the chip-select-hold count. Then chip select is high with the address held for the address-hold count. A count of zero removes its phase.
- R4: A write uses write enable as its strobe, and output enable stays high. The data drive enable is high on exactly the cycles where chip select is low. A read never raises write enable or the drive enable.
- R5: Read data is sampled on the last strobe cycle of each beat. A beat from an 8-bit bank keeps only mem_din[7:0], and its upper byte is returned as zero.
- R6: With page enable set, the strobe stays low across four beats. Beat k (0..3) uses address offset+k (8-bit bank) or offset+2k (16-bit bank). Beat 0 lasts access+1 cycles and each later beat lasts the page count, where a page count of 0 acts as 1. Read beat k is returned in rd_data[16k+15:16k].
- R7: done is high for exactly one cycle, which is the cycle after the last busy cycle. rd_data is valid in that cycle.
- R8: req_ready is low on every busy cycle. A request presented while busy is not taken: no other bank's chip select moves, and a request that is withdrawn in the done cycle starts nothing.
- R9: The configuration of a bank is captured when a request is accepted. A configuration write made during an access does not change that access, and it applies to the next one.
- R10: Only the chip select of the requested bank goes low. At most one chip select is low at any time.
- R11: Write beat k drives req_wdata[16k+15:16k] on mem_dout. An 8-bit bank drives that slice's low byte with a zero upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank whose configuration is written |
| cfg_wdata | input | 27 | Configuration word (field layout in R2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on this cycle's edge |
| req_bank | input | 2 | Target bank |
| req_ofs | input | 20 | Byte offset within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data, four 16-bit beats |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 64 | Read data, four 16-bit beats |
| mem_addr | output | 20 | External address |
| mem_cs_n | output | 4 | Active-low chip select for each bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Write data to the bus |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 16 | Read data from the bus |

## Verification
The bench counts the cycles spent in each phase and checks them against the programmed counts. This covers all-zero timing, where a design without a minimum access cycle would never assert its strobe, and mixes of zero and nonzero phases, where a design that failed to skip empty phases would add idle cycles. Maximum counts are also used, where a narrow counter would wrap and cut the access short. Page bursts are run with page count 0 and 2, and with both widths. These catch a wrong address step, a zero page count treated as zero cycles, and data taken from the wrong beat. A configuration write and a competing request are injected during an access. A controller that read its configuration live would change the current timing, and one that ignored ready would start a second bank's chip select.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int TIM_W  = 4;
    localparam int ACC_W  = 5;
    localparam int CNT_W  = ACC_W + 1;
    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic             page_en;
        logic             wide;
        logic [TIM_W-1:0] t_pg;
        logic [TIM_W-1:0] t_ah;
        logic [TIM_W-1:0] t_ch;
        logic [ACC_W-1:0] t_acc;
        logic [TIM_W-1:0] t_cs;
        logic [TIM_W-1:0] t_as;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASET,
        PH_CSSET,
        PH_ACC,
        PH_PAGE,
        PH_CSHOLD,
        PH_AHOLD
    } phase_t;
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
    import smc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  bank_cfg_t         wr_cfg,
    input  logic [BANK_W-1:0] rd_bank,
    output bank_cfg_t         rd_cfg
);
    bank_cfg_t cfg_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cfg_t cfg_d;
        always_comb begin
            cfg_d = cfg_q[b];
            if (wr_en && wr_bank == BANK_W'(b)) cfg_d = wr_cfg;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[b] <= '0;
            else        cfg_q[b] <= cfg_d;
        end
    end

    assign rd_cfg = cfg_q[rd_bank];
endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bank_cfg_t         cfg_i,
    output phase_t            phase_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              sample_o,
    output logic              adv_o,
    output logic              done_o,
    output logic              wide_o
);
    typedef struct packed {
        phase_t            ph;
        logic [CNT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic              done;
        bank_cfg_t         cfg;
    } seq_st_t;

    seq_st_t st_d, st_q;
    phase_t  nxt;
    logic    leave;

    function automatic logic [CNT_W-1:0] ph_len(phase_t p, bank_cfg_t c);
        case (p)
            PH_ASET:   return CNT_W'(c.t_as);
            PH_CSSET:  return CNT_W'(c.t_cs);
            PH_ACC:    return CNT_W'(c.t_acc) + 1'b1;
            PH_PAGE:   return (c.t_pg == '0) ? CNT_W'(1) : CNT_W'(c.t_pg);
            PH_CSHOLD: return CNT_W'(c.t_ch);
            PH_AHOLD:  return CNT_W'(c.t_ah);
            default:   return CNT_W'(1);
        endcase
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        nxt      = st_q.ph;
        leave    = 1'b0;
        sample_o = 1'b0;
        adv_o    = 1'b0;
        if (st_q.ph == PH_IDLE) begin
            if (start) begin
                st_d.cfg  = cfg_i;
                st_d.beat = '0;
                leave     = 1'b1;
                if (cfg_i.t_as != '0)      nxt = PH_ASET;
                else if (cfg_i.t_cs != '0) nxt = PH_CSSET;
                else                       nxt = PH_ACC;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            leave = 1'b1;
            case (st_q.ph)
                PH_ASET:  nxt = (st_q.cfg.t_cs != '0) ? PH_CSSET : PH_ACC;
                PH_CSSET: nxt = PH_ACC;
                PH_ACC, PH_PAGE: begin
                    sample_o = 1'b1;
                    if (st_q.cfg.page_en && st_q.beat != BEAT_W'(BEATS - 1)) begin
                        nxt       = PH_PAGE;
                        adv_o     = 1'b1;
                        st_d.beat = st_q.beat + 1'b1;
                    end else if (st_q.cfg.t_ch != '0) nxt = PH_CSHOLD;
                    else if (st_q.cfg.t_ah != '0)     nxt = PH_AHOLD;
                    else                              nxt = PH_IDLE;
                end
                PH_CSHOLD: nxt = (st_q.cfg.t_ah != '0) ? PH_AHOLD : PH_IDLE;
                default:   nxt = PH_IDLE;
            endcase
            st_d.done = (nxt == PH_IDLE);
        end
        if (leave) begin
            st_d.ph  = nxt;
            st_d.cnt = ph_len(nxt, st_d.cfg) - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign phase_o = st_q.ph;
    assign beat_o  = st_q.beat;
    assign done_o  = st_q.done;
    assign wide_o  = st_q.cfg.wide;

    // R9: captured bank configuration holds for the whole access
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && $past(st_q.ph) != PH_IDLE) |-> $stable(st_q.cfg));
    // R6: later beats only exist in page mode
    p_beat_page_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.beat != '0) |-> st_q.cfg.page_en);
    // R7: the done pulse coincides with a return to idle
    p_done_in_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.ph == PH_IDLE));
endmodule

// File: rtl/smc_beat_path.sv
module smc_beat_path
    import smc_pkg::*;
#(
    parameter int OFS_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [BEATS*DATA_W-1:0] wdata_i,
    input  logic                    wide_i,
    input  logic [BEAT_W-1:0]       beat_i,
    input  logic                    sample_i,
    input  logic                    adv_i,
    input  logic [DATA_W-1:0]       din_i,
    output logic [OFS_W-1:0]        addr_o,
    output logic [DATA_W-1:0]       dout_o,
    output logic [BEATS*DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [OFS_W-1:0]        addr;
        logic [BEATS*DATA_W-1:0] rbuf;
        logic [BEATS*DATA_W-1:0] wbuf;
    } bp_st_t;

    bp_st_t           bp_d, bp_q;
    logic [DATA_W-1:0] wslice;

    always_comb begin
        bp_d = bp_q;
        if (start) begin
            bp_d.addr = ofs_i;
            bp_d.rbuf = '0;
            bp_d.wbuf = wdata_i;
        end else begin
            if (sample_i)
                bp_d.rbuf[DATA_W*beat_i +: DATA_W] =
                    wide_i ? din_i : {{HALF_W{1'b0}}, din_i[HALF_W-1:0]};
            if (adv_i)
                bp_d.addr = bp_q.addr + (wide_i ? OFS_W'(2) : OFS_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bp_q <= '0;
        else        bp_q <= bp_d;
    end

    assign wslice  = bp_q.wbuf[DATA_W*beat_i +: DATA_W];
    assign dout_o  = wide_i ? wslice : {{HALF_W{1'b0}}, wslice[HALF_W-1:0]};
    assign addr_o  = bp_q.addr;
    assign rdata_o = bp_q.rbuf;
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
    import smc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int OFS_W     = 20,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [BANK_W-1:0]       cfg_bank,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [OFS_W-1:0]        req_ofs,
    input  logic                    req_write,
    input  logic [BEATS*DATA_W-1:0] req_wdata,
    output logic                    done,
    output logic [BEATS*DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]        mem_addr,
    output logic [NUM_BANKS-1:0]    mem_cs_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [DATA_W-1:0]       mem_dout,
    output logic                    mem_dout_en,
    input  logic [DATA_W-1:0]       mem_din
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              wr;
    } top_st_t;

    top_st_t           st_d, st_q;
    bank_cfg_t         sel_cfg;
    phase_t            phase;
    logic [BEAT_W-1:0] beat;
    logic              start, sample, adv, wide;
    logic              cs_act, strobe;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    smc_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_cfg  (bank_cfg_t'(cfg_wdata)),
        .rd_bank (req_bank),
        .rd_cfg  (sel_cfg)
    );

    smc_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_i    (sel_cfg),
        .phase_o  (phase),
        .beat_o   (beat),
        .sample_o (sample),
        .adv_o    (adv),
        .done_o   (done),
        .wide_o   (wide)
    );

    smc_beat_path #(.OFS_W(OFS_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ofs_i    (req_ofs),
        .wdata_i  (req_wdata),
        .wide_i   (wide),
        .beat_i   (beat),
        .sample_i (sample),
        .adv_i    (adv),
        .din_i    (mem_din),
        .addr_o   (mem_addr),
        .dout_o   (mem_dout),
        .rdata_o  (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.bank = req_bank;
            st_d.wr   = req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_act = (phase == PH_CSSET) || (phase == PH_ACC) ||
                    (phase == PH_PAGE)  || (phase == PH_CSHOLD);
    assign strobe = (phase == PH_ACC) || (phase == PH_PAGE);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign mem_cs_n[b] = !(cs_act && st_q.bank == BANK_W'(b));
    end

    assign mem_oe_n    = !(strobe && !st_q.wr);
    assign mem_we_n    = !(strobe && st_q.wr);
    assign mem_dout_en = cs_act && st_q.wr;

    // R10: never more than one chip select active
    p_one_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    // R3: a strobe only appears inside a chip-select window
    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> ($countones(~mem_cs_n) == 1));
    // R4: read and write strobes are exclusive
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R4: data is driven only with a chip select and never during a read strobe
    p_drive_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (mem_oe_n && $countones(~mem_cs_n) == 1));
    // R8: an accepted request makes the controller busy on the next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_smc_ctrl.sv
module test_smc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [26:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [19:0] req_ofs = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        done;
    logic [63:0] rd_data;
    logic [19:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dout_en;
    logic [15:0] mem_dout, mem_din;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench mirror of each bank's settings
    int  m_as[4], m_cs[4], m_acc[4], m_ch[4], m_ah[4], m_pg[4];
    bit  m_wide[4], m_page[4];
    logic [15:0] wmem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    smc_ctrl i_smc_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_ofs(req_ofs), .req_write(req_write),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    // device model: read pattern from the address, capture writes
    assign mem_din = mem_oe_n ? 16'h0000 : {mem_addr[7:0] ^ 8'hA5, mem_addr[7:0]};
    always @(negedge clk) if (!mem_we_n) wmem[mem_addr[7:0]] <= mem_dout;

    function automatic logic [15:0] pat(input int a, input bit wide);
        logic [7:0] lo;
        lo = 8'(a);
        return wide ? {lo ^ 8'hA5, lo} : {8'h00, lo};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [26:0] pack_cfg(input int tas, tcs, tacc, tch, tah, tpg,
                                             input bit wide, page);
        return (27'(tas) & 27'hF) | ((27'(tcs) & 27'hF) << 4) | ((27'(tacc) & 27'h1F) << 8)
             | ((27'(tch) & 27'hF) << 13) | ((27'(tah) & 27'hF) << 17)
             | ((27'(tpg) & 27'hF) << 21) | (27'(wide) << 25) | (27'(page) << 26);
    endfunction

    task automatic set_mirror(input int b, tas, tcs, tacc, tch, tah, tpg, input bit wide, page);
        m_as[b] = tas; m_cs[b] = tcs; m_acc[b] = tacc; m_ch[b] = tch;
        m_ah[b] = tah; m_pg[b] = tpg; m_wide[b] = wide; m_page[b] = page;
    endtask

    // R2: configuration write through the port
    task automatic cfg_write(input int b, tas, tcs, tacc, tch, tah, tpg, input bit wide, page);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 2'(b);
        cfg_wdata = pack_cfg(tas, tcs, tacc, tch, tah, tpg, wide, page);
        @(negedge clk);
        cfg_we = 1'b0;
        set_mirror(b, tas, tcs, tacc, tch, tah, tpg, wide, page);
    endtask

    // one access with phase measurement; mode 1 injects a config write and
    // a competing request for bank 3 while busy
    task automatic do_access(input string tag, input int b, input int ofs, input bit wr,
                             input logic [63:0] wd, input int mode);
        int e_as, e_cs, e_st, e_ch, e_ah, e_tot, beats, step, pgl;
        int n_as = 0, n_cs = 0, n_st = 0, n_ch = 0, n_ah = 0, cyc = 0;
        bit seen_cs = 0, seen_st = 0;
        bit bad_cs = 0, bad_rdy = 0, bad_drv = 0, bad_other = 0, bad_hold = 0;
        logic [19:0] last_addr = '0;
        bit st_low, cs_low;
        beats = m_page[b] ? 4 : 1;
        step  = m_wide[b] ? 2 : 1;
        pgl   = (m_pg[b] == 0) ? 1 : m_pg[b];
        e_as = m_as[b]; e_cs = m_cs[b]; e_ch = m_ch[b]; e_ah = m_ah[b];
        e_st = m_acc[b] + 1 + (beats - 1) * pgl;
        e_tot = e_as + e_cs + e_st + e_ch + e_ah;
        for (int k = 0; k < 256; k++) wmem[k] = 16'h0;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_ofs = 20'(ofs);
        req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 3000) begin
            cs_low = !mem_cs_n[b];
            st_low = wr ? !mem_we_n : !mem_oe_n;
            if ((mem_cs_n | (4'b1 << b)) != 4'hF) bad_cs = 1;
            if (req_ready) bad_rdy = 1;
            if (mem_dout_en != (wr && cs_low)) bad_drv = 1;
            if (wr ? !mem_oe_n : !mem_we_n) bad_drv = 1;
            if (st_low && !cs_low) bad_cs = 1;
            if (st_low) begin
                n_st++; seen_st = 1; seen_cs = 1; last_addr = mem_addr;
            end else if (cs_low) begin
                seen_cs = 1;
                if (seen_st) begin n_ch++; if (mem_addr != last_addr) bad_hold = 1; end
                else n_cs++;
            end else begin
                if (seen_cs) begin n_ah++; if (mem_addr != last_addr) bad_hold = 1; end
                else n_as++;
            end
            if (mode == 1 && cyc == 1) begin
                cfg_we = 1'b1; cfg_bank = 2'(b);
                cfg_wdata = pack_cfg(1, 1, 2, 1, 1, 1, m_wide[b], m_page[b]);
                req_valid = 1'b1; req_bank = 2'd3; req_ofs = 20'h00040; req_write = 1'b0;
            end
            if (mode == 1 && cyc == 2) cfg_we = 1'b0;
            if (mode == 1 && !mem_cs_n[3]) bad_other = 1;
            @(negedge clk);
            cyc++;
        end
        if (mode == 1) begin
            req_valid = 1'b0;
            set_mirror(b, 1, 1, 2, 1, 1, 1, m_wide[b], m_page[b]);
        end
        check(cyc < 3000, {tag, " R7 watchdog"}, cyc, e_tot);
        check(n_as == e_as, {tag, " R3 address setup cycles"}, n_as, e_as);
        check(n_cs == e_cs, {tag, " R3 cs setup cycles"}, n_cs, e_cs);
        check(n_st == e_st, {tag, (beats > 1) ? " R6 strobe cycles" : " R3 strobe cycles"}, n_st, e_st);
        check(n_ch == e_ch, {tag, " R3 cs hold cycles"}, n_ch, e_ch);
        check(n_ah == e_ah, {tag, " R3 address hold cycles"}, n_ah, e_ah);
        check(!bad_hold, {tag, " R3 address held after strobe"}, bad_hold, 0);
        check(cyc == e_tot, {tag, " R7 done timing"}, cyc, e_tot);
        check(!bad_cs, {tag, " R10 only target chip select"}, bad_cs, 0);
        check(!bad_rdy, {tag, " R8 ready low while busy"}, bad_rdy, 0);
        check(!bad_drv, {tag, " R4 strobe and drive enable"}, bad_drv, 0);
        check(last_addr == 20'(ofs + (beats - 1) * step), {tag, " R6 last beat address"},
              last_addr, ofs + (beats - 1) * step);
        if (mode == 1) check(!bad_other, {tag, " R8 busy request ignored"}, bad_other, 0);
        if (!wr) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] exp_b;
                exp_b = (k < beats) ? pat(ofs + k * step, m_wide[b]) : 16'h0;
                if (m_wide[b] != 1'b1 && mode != 1) exp_b = (k < beats) ? pat(ofs + k * step, 0) : 16'h0;
                check(rd_data[16*k +: 16] == exp_b,
                      {tag, m_wide[b] ? " R6 read beat" : " R5 read beat"}, rd_data[16*k +: 16], exp_b);
            end
        end else begin
            for (int k = 0; k < beats; k++) begin
                logic [15:0] exp_w;
                exp_w = m_wide[b] ? wd[16*k +: 16] : {8'h00, wd[16*k +: 8]};
                check(wmem[8'(ofs + k * step)] == exp_w, {tag, " R11 write beat"},
                      wmem[8'(ofs + k * step)], exp_w);
            end
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
        check(req_ready == 1'b1 && mem_cs_n == 4'hF, {tag, " R8 idle after done"},
              {req_ready, mem_cs_n}, 5'h1F);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_cs_n == 4'hF, "R1 chip selects after reset", mem_cs_n, 4'hF);
        check(mem_oe_n && mem_we_n, "R1 strobes after reset", {mem_oe_n, mem_we_n}, 2'b11);
        check(!mem_dout_en && !done, "R1 drive and done after reset", {mem_dout_en, done}, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_default_read();
        set_mirror(0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_access("R2 default bank0 read", 0, 'h012, 0, '0, 0);
    endtask

    task automatic t_wide_read();
        cfg_write(1, 2, 3, 4, 1, 2, 0, 1, 0);
        do_access("R3 wide read", 1, 'h020, 0, '0, 0);
    endtask

    task automatic t_narrow_write();
        cfg_write(2, 1, 2, 3, 2, 1, 0, 0, 0);
        do_access("R4 narrow write", 2, 'h030, 1, 64'h1111_2222_3333_C3A7, 0);
    endtask

    task automatic t_zero_phases();
        cfg_write(3, 0, 5, 0, 0, 3, 0, 1, 0);
        do_access("R3 zero phases read", 3, 'h044, 0, '0, 0);
        do_access("R4 zero phases write", 3, 'h046, 1, 64'h0000_0000_0000_BEEF, 0);
    endtask

    task automatic t_page();
        cfg_write(1, 1, 1, 3, 2, 1, 2, 1, 1);
        do_access("R6 wide page read", 1, 'h050, 0, '0, 0);
        cfg_write(2, 2, 0, 1, 0, 0, 0, 0, 1);
        do_access("R6 narrow page write", 2, 'h060, 1, 64'hA1B2_C3D4_E5F6_0718, 0);
        do_access("R5 narrow page read", 2, 'h070, 0, '0, 0);
    endtask

    task automatic t_max();
        cfg_write(0, 15, 15, 31, 15, 15, 15, 1, 0);
        do_access("R3 maximum counts", 0, 'h080, 0, '0, 0);
    endtask

    task automatic t_midcfg();
        cfg_write(1, 3, 2, 6, 2, 3, 0, 1, 0);
        do_access("R9 config write during access", 1, 'h090, 0, '0, 1);
        do_access("R9 new config on next access", 1, 'h094, 0, '0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_default_read();
        t_wide_read();
        t_narrow_write();
        t_zero_phases();
        t_page();
        t_max();
        t_midcfg();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule